// File: doc/BRIEF.md
# Multi-Target Vector Transfer Engine

This block moves a vector of words between a local memory and a group of `N_DEV` target devices. Every target is reached at the same internal offset, given once per transfer as a base address. Three operations are offered. A broadcast write sends the whole local vector to every target at once. A scatter write hands each target its own equal slice of the vector. A gather read pulls one slice from each target back into local memory, one target after another.

Each transfer is strictly paced, so that a controller sequencing a parallel machine can rely on it. With every target ready, the number of busy cycles depends only on the operation and the length, never on the data. Every data group closes with a checksum beat. On writes the engine sends a CRC for the receiving target to verify. On gather reads the engine fetches the target's CRC and compares it with its own, and any mismatch is reported on the error output when the transfer completes.

Top module: `xfer_engine`

## Requirements
- R1: Operation code 0 (broadcast) reads local addresses 0..L-1 in order and writes word j to internal address base+j of every target. One data beat completes only in a cycle where all targets are ready.
- R2: Operation code 1 (scatter) uses slice size S = L/N_DEV. Target k receives local words k*S..k*S+S-1 at internal addresses base..base+S-1. Targets are served in ascending index order, and a beat completes when the addressed target is ready.
- R3: Operation code 2 (gather) reads target k's internal address base+j into local address k*S+j. Targets are served in ascending order, and `dev_we_o` stays low for the whole transfer.
- R4: After its data words, each write group ends with one beat that has `dev_crc_o` high. A broadcast has one such beat, sent to all targets. A scatter has one per target. The beat carries the CRC of the words sent to that target: polynomial 0x1021, initial value all ones, one shift per data bit taken MSB first, with no final inversion.
- R5: In gather, after each slice the engine reads one beat with `dev_crc_o` high from the same target and compares it with the CRC (as in R4) of the words read from it. Any mismatch makes `err_o` high in the cycle where `done_o` pulses.
- R6: With all targets always ready, `busy_o` is high for exactly L+1 cycles for a broadcast and L+N_DEV cycles for a scatter or gather, whatever the data or CRC outcome.
- R7: `done_o` is a one-cycle pulse in the cycle after the final beat, and `busy_o` is low in that cycle.
- R8: A start is rejected in any of these cases: L = 0, operation code 3, or L not a multiple of N_DEV for codes 1 and 2. A rejected start gives a one-cycle `err_o` pulse in the following cycle, with no `busy_o`, no `done_o` and no request.
- R9: A start strobe while `busy_o` is high is ignored. The running transfer keeps its operation, base and length, and nothing is written at the ignored start's addresses.
- R10: After reset, `busy_o`, `done_o`, `err_o`, `dev_req_o` and `lmem_we_o` are all low.
- R11: `dev_req_o` is all zero while idle. During scatter and gather, at most one request bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| op_i | input | 2 | Operation: 0 broadcast, 1 scatter, 2 gather |
| base_i | input | AW | Internal base address used in every target |
| len_i | input | LW | Vector length in words |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Rejected start or gather CRC mismatch |
| lmem_addr_o | output | LW | Local memory word address |
| lmem_rdata_i | input | DW | Local memory read data (same cycle) |
| lmem_we_o | output | 1 | Local memory write enable (gather) |
| lmem_wdata_o | output | DW | Local memory write data |
| dev_req_o | output | N_DEV | Per-target request |
| dev_we_o | output | 1 | Beat is a write |
| dev_crc_o | output | 1 | Beat is a CRC beat |
| dev_addr_o | output | AW | Internal address of the beat |
| dev_wdata_o | output | DW | Write data or CRC to targets |
| dev_ready_i | input | N_DEV | Per-target ready |
| dev_rdata_i | input | N_DEV*DW | Per-target read data, target k at bits k*DW |

## Verification
The bench goes after the slice arithmetic at target boundaries. A wrong slice offset would put word k*S in the wrong target or at the wrong local address. It corrupts one target's gather CRC and checks that the error appears on the done pulse, without any change to the cycle count. A design whose latency depended on the data, or whose error was not carried across slices, would fail there. It also issues rejected starts (zero length, code 3, non-multiple length) and a start strobe in the middle of a transfer. A design that missed these would raise requests, or would write the region at the ignored start's base.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
    typedef enum logic [1:0] {
        OP_BCAST   = 2'd0,
        OP_SCATTER = 2'd1,
        OP_GATHER  = 2'd2,
        OP_NONE    = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_CRC  = 2'd2
    } st_e;
endpackage

// File: rtl/xfer_crc.sv
module xfer_crc #(
    parameter int          DW   = 16,
    parameter logic [DW-1:0] POLY = 'h1021
) (
    input  logic [DW-1:0] crc_i,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] crc_o
);
    // Bit-serial update unrolled over one data word, MSB first
    always_comb begin
        logic [DW-1:0] c;
        logic          fb;
        c = crc_i;
        for (int i = DW - 1; i >= 0; i--) begin
            fb = c[DW-1] ^ data_i[i];
            c  = {c[DW-2:0], 1'b0};
            if (fb) c = c ^ POLY;
        end
        crc_o = c;
    end
endmodule

// File: rtl/xfer_startchk.sv
module xfer_startchk
    import xfer_pkg::*;
#(
    parameter int N_DEV = 4,
    parameter int LW    = 8
) (
    input  op_e           op_i,
    input  logic [LW-1:0] len_i,
    output logic          ok_o,
    output logic [LW-1:0] slice_o
);
    localparam int LOGN = (N_DEV > 1) ? $clog2(N_DEV) : 0;
    localparam logic [LW-1:0] NMASK = LW'(N_DEV - 1);

    logic split_op;
    assign split_op = (op_i == OP_SCATTER) || (op_i == OP_GATHER);

    always_comb begin
        ok_o = (len_i != '0) && (op_i != OP_NONE);
        if (split_op && ((len_i & NMASK) != '0)) ok_o = 1'b0;
        slice_o = split_op ? (len_i >> LOGN) : len_i;
    end
endmodule

// File: rtl/xfer_fanout.sv
module xfer_fanout #(
    parameter int N_DEV = 4,
    parameter int DW    = 16,
    parameter int KW    = 2
) (
    input  logic                  active_i,
    input  logic                  all_i,
    input  logic [KW-1:0]         k_i,
    input  logic [N_DEV-1:0]      ready_i,
    input  logic [N_DEV*DW-1:0]   rdata_i,
    output logic [N_DEV-1:0]      req_o,
    output logic                  accept_o,
    output logic [DW-1:0]         rdata_o
);
    logic [DW-1:0] rd_arr [N_DEV];

    for (genvar g = 0; g < N_DEV; g++) begin : g_dev
        assign req_o[g]  = active_i && (all_i || (k_i == KW'(g)));
        assign rd_arr[g] = rdata_i[g*DW +: DW];
    end

    assign accept_o = active_i && (all_i ? (&ready_i) : ready_i[k_i]);
    assign rdata_o  = rd_arr[k_i];
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
    import xfer_pkg::*;
#(
    parameter int N_DEV = 4,
    parameter int DW    = 16,
    parameter int AW    = 8,
    parameter int LW    = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic [1:0]          op_i,
    input  logic [AW-1:0]       base_i,
    input  logic [LW-1:0]       len_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                err_o,
    output logic [LW-1:0]       lmem_addr_o,
    input  logic [DW-1:0]       lmem_rdata_i,
    output logic                lmem_we_o,
    output logic [DW-1:0]       lmem_wdata_o,
    output logic [N_DEV-1:0]    dev_req_o,
    output logic                dev_we_o,
    output logic                dev_crc_o,
    output logic [AW-1:0]       dev_addr_o,
    output logic [DW-1:0]       dev_wdata_o,
    input  logic [N_DEV-1:0]    dev_ready_i,
    input  logic [N_DEV*DW-1:0] dev_rdata_i
);
    localparam int            KW       = (N_DEV > 1) ? $clog2(N_DEV) : 1;
    localparam logic [KW-1:0] K_LAST   = KW'(N_DEV - 1);
    localparam logic [DW-1:0] CRC_INIT = '1;

    typedef struct packed {
        st_e           st;
        op_e           op;
        logic [AW-1:0] base;
        logic [LW-1:0] slice;
        logic [LW-1:0] idx;
        logic [LW-1:0] w;
        logic [KW-1:0] k;
        logic [DW-1:0] crc;
        logic          bad;
        logic          done;
        logic          err;
    } state_t;

    state_t q, d;

    logic          start_ok;
    logic [LW-1:0] start_slice;
    logic          active, all_dev, accept;
    logic [DW-1:0] rdata_sel, crc_in_word, crc_nxt;
    logic          is_gather, last_dev, crc_bad;

    xfer_startchk #(.N_DEV(N_DEV), .LW(LW)) u_startchk (
        .op_i    (op_e'(op_i)),
        .len_i   (len_i),
        .ok_o    (start_ok),
        .slice_o (start_slice)
    );

    assign active  = (q.st != ST_IDLE);
    assign all_dev = (q.op == OP_BCAST);

    xfer_fanout #(.N_DEV(N_DEV), .DW(DW), .KW(KW)) u_fanout (
        .active_i (active),
        .all_i    (all_dev),
        .k_i      (q.k),
        .ready_i  (dev_ready_i),
        .rdata_i  (dev_rdata_i),
        .req_o    (dev_req_o),
        .accept_o (accept),
        .rdata_o  (rdata_sel)
    );

    assign is_gather   = (q.op == OP_GATHER);
    assign crc_in_word = is_gather ? rdata_sel : lmem_rdata_i;

    xfer_crc #(.DW(DW)) u_crc (
        .crc_i  (q.crc),
        .data_i (crc_in_word),
        .crc_o  (crc_nxt)
    );

    assign last_dev = all_dev || (q.k == K_LAST);
    assign crc_bad  = is_gather && (rdata_sel != q.crc);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (start_ok) begin
                        d.st    = ST_DATA;
                        d.op    = op_e'(op_i);
                        d.base  = base_i;
                        d.slice = start_slice;
                        d.idx   = '0;
                        d.w     = '0;
                        d.k     = '0;
                        d.crc   = CRC_INIT;
                        d.bad   = 1'b0;
                    end else begin
                        d.err = 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (accept) begin
                    d.crc = crc_nxt;
                    d.idx = q.idx + LW'(1);
                    d.w   = q.w + LW'(1);
                    if (q.w == q.slice - LW'(1)) d.st = ST_CRC;
                end
            end
            ST_CRC: begin
                if (accept) begin
                    if (last_dev) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.err  = q.bad || crc_bad;
                        d.bad  = 1'b0;
                    end else begin
                        d.st  = ST_DATA;
                        d.k   = q.k + KW'(1);
                        d.w   = '0;
                        d.crc = CRC_INIT;
                        d.bad = q.bad || crc_bad;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '{st: ST_IDLE, op: OP_BCAST, crc: CRC_INIT, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o       = active;
    assign done_o       = q.done;
    assign err_o        = q.err;
    assign lmem_addr_o  = q.idx;
    assign lmem_we_o    = (q.st == ST_DATA) && is_gather && accept;
    assign lmem_wdata_o = rdata_sel;
    assign dev_we_o     = active && !is_gather;
    assign dev_crc_o    = (q.st == ST_CRC);
    assign dev_addr_o   = q.base + AW'(q.w);
    assign dev_wdata_o  = (q.st == ST_CRC) ? q.crc : lmem_rdata_i;
endmodule

// File: rtl/xfer_engine_chk.sv
module xfer_engine_chk #(
    parameter int N_DEV = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             busy_o,
    input logic             done_o,
    input logic             err_o,
    input logic [N_DEV-1:0] dev_req_o,
    input logic             dev_we_o,
    input logic             dev_crc_o,
    input logic             lmem_we_o
);
    // R7
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R7
    done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && $past(busy_o)));

    // R11
    idle_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (dev_req_o == '0));

    // R11
    gather_single_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !dev_we_o) |-> $onehot(dev_req_o));

    // R3
    gather_local_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lmem_we_o |-> (busy_o && !dev_we_o && !dev_crc_o));

    // R8
    reject_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_o && !done_o) |-> !busy_o);
endmodule

bind xfer_engine xfer_engine_chk #(.N_DEV(N_DEV)) u_chk (.*);

// File: tb/xfer_engine_test.sv
module xfer_engine_test;
    localparam int N  = 4;
    localparam int DW = 16;
    localparam int AW = 8;
    localparam int LW = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n;
    logic            start;
    logic [1:0]      op;
    logic [AW-1:0]   base;
    logic [LW-1:0]   len;
    logic            busy, done, err;
    logic [LW-1:0]   lmem_addr;
    logic [DW-1:0]   lmem_rdata;
    logic            lmem_we;
    logic [DW-1:0]   lmem_wdata;
    logic [N-1:0]    dev_req;
    logic            dev_we, dev_crc;
    logic [AW-1:0]   dev_addr;
    logic [DW-1:0]   dev_wdata;
    logic [N-1:0]    dev_ready;
    logic [N*DW-1:0] dev_rdata;

    xfer_engine #(.N_DEV(N), .DW(DW), .AW(AW), .LW(LW)) uut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .base_i(base),
        .len_i(len), .busy_o(busy), .done_o(done), .err_o(err),
        .lmem_addr_o(lmem_addr), .lmem_rdata_i(lmem_rdata), .lmem_we_o(lmem_we),
        .lmem_wdata_o(lmem_wdata), .dev_req_o(dev_req), .dev_we_o(dev_we),
        .dev_crc_o(dev_crc), .dev_addr_o(dev_addr), .dev_wdata_o(dev_wdata),
        .dev_ready_i(dev_ready), .dev_rdata_i(dev_rdata)
    );

    int n_chk  = 0;
    int n_fail = 0;

    logic [DW-1:0] lmem [256];
    logic [DW-1:0] dmem [N][256];
    logic [DW-1:0] rx_crc [N];
    logic [DW-1:0] corrupt [N];
    int cur_base, cur_slice;
    int last_k, order_bad;
    bit rnd_ready;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_word(input logic [15:0] c, input logic [15:0] dw);
        logic [15:0] r;
        r = c;
        for (int b = 15; b >= 0; b--) begin
            if (r[15] != dw[b]) r = (r << 1) ^ 16'h1021;
            else                r = r << 1;
        end
        return r;
    endfunction

    function automatic logic [15:0] crc_local(input int s, input int n);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int i = 0; i < n; i++) c = crc_word(c, lmem[(s + i) % 256]);
        return c;
    endfunction

    function automatic logic [15:0] crc_dev(input int k, input int s, input int n);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int i = 0; i < n; i++) c = crc_word(c, dmem[k][(s + i) % 256]);
        return c;
    endfunction

    assign lmem_rdata = lmem[lmem_addr];

    always @* begin
        for (int k = 0; k < N; k++) begin
            if (dev_crc)
                dev_rdata[k*DW +: DW] = crc_dev(k, cur_base, cur_slice) ^ corrupt[k];
            else
                dev_rdata[k*DW +: DW] = dmem[k][dev_addr];
        end
    end

    // target and local memory models
    always @(posedge clk) begin
        for (int k = 0; k < N; k++) begin
            if (dev_req[k] && dev_ready[k] && dev_we) begin
                if (dev_crc) rx_crc[k] <= dev_wdata;
                else         dmem[k][dev_addr] <= dev_wdata;
            end
        end
        if (lmem_we) lmem[lmem_addr] <= lmem_wdata;
        if ($countones(dev_req) == 1) begin
            for (int k = 0; k < N; k++) begin
                if (dev_req[k] && dev_ready[k]) begin
                    if (k < last_k) order_bad++;
                    last_k = k;
                end
            end
        end
    end

    always @(negedge clk) begin
        for (int k = 0; k < N; k++)
            dev_ready[k] <= rnd_ready ? (($urandom % 10) < 7) : 1'b1;
    end

    function automatic int exp_cycles(input int o, input int l);
        return (o == 0) ? l + 1 : l + N;
    endfunction

    task automatic run(input int o, input int b, input int l, input bit inject,
                       output int cyc, output bit errv);
        int wd;
        cur_base  = b;
        cur_slice = (o == 0) ? l : l / N;
        last_k    = 0;
        order_bad = 0;
        @(negedge clk);
        start = 1'b1; op = 2'(o); base = AW'(b); len = LW'(l);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        wd  = 0;
        while (!done && wd < 5000) begin
            if (busy) cyc++;
            if (inject && cyc == 3) begin
                start = 1'b1; op = 2'd0; base = 8'hE0; len = 8'd4;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            wd++;
        end
        start = 1'b0;
        if (wd >= 5000) check(1'b0, "R7 watchdog: done never seen", wd, 0);
        errv = err;
        @(negedge clk);
        check(!done && !busy, "R7 done is single pulse, idle after", int'(done), 0);
    endtask

    task automatic reject(input int o, input int l, input string tag);
        bit seen_req;
        @(negedge clk);
        start = 1'b1; op = 2'(o); base = 8'h50; len = LW'(l);
        @(negedge clk);
        start = 1'b0;
        check(err && !busy && !done, tag, {29'd0, err, busy, done}, 3'b100);
        seen_req = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (dev_req != '0 || busy || err) seen_req = 1'b1;
        end
        check(!seen_req, {tag, " (R8 no activity)"}, int'(seen_req), 0);
    endtask

    function automatic int cmp_bcast(input int b, input int l);
        int bad = 0;
        for (int k = 0; k < N; k++) begin
            for (int j = 0; j < l; j++)
                if (dmem[k][(b + j) % 256] !== lmem[j]) bad++;
            if (rx_crc[k] !== crc_local(0, l)) bad++;
        end
        return bad;
    endfunction

    function automatic int cmp_scatter(input int b, input int l);
        int bad = 0;
        int s = l / N;
        for (int k = 0; k < N; k++) begin
            for (int j = 0; j < s; j++)
                if (dmem[k][(b + j) % 256] !== lmem[k*s + j]) bad++;
            if (rx_crc[k] !== crc_local(k*s, s)) bad++;
        end
        return bad;
    endfunction

    function automatic int cmp_gather(input int b, input int l);
        int bad = 0;
        int s = l / N;
        for (int k = 0; k < N; k++)
            for (int j = 0; j < s; j++)
                if (lmem[k*s + j] !== dmem[k][(b + j) % 256]) bad++;
        return bad;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int  cyc;
        bit  ev;
        int  bad;
        void'($urandom(32'd4242));
        rnd_ready = 1'b0;
        dev_ready = '1;
        start = 1'b0; op = '0; base = '0; len = '0;
        for (int i = 0; i < 256; i++) begin
            lmem[i] = 16'(i * 3 + 1);
            for (int k = 0; k < N; k++) dmem[k][i] = 16'hDEAD;
        end
        for (int k = 0; k < N; k++) begin
            rx_crc[k]  = '0;
            corrupt[k] = '0;
        end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10
        check(!busy && !done && !err && dev_req == '0 && !lmem_we, "R10 reset idle",
              {busy, done, err, lmem_we}, 0);

        // R1 / R4 / R6 directed broadcast
        for (int i = 0; i < 8; i++) lmem[i] = 16'h1000 + 16'(i);
        run(0, 8'h10, 8, 1'b0, cyc, ev);
        check(cyc == exp_cycles(0, 8), "R6 broadcast busy cycles", cyc, exp_cycles(0, 8));
        bad = cmp_bcast(8'h10, 8);
        check(bad == 0, "R1 R4 broadcast data and crc", bad, 0);
        check(!ev, "R5 broadcast no error", int'(ev), 0);

        // R2 / R4 directed scatter
        for (int i = 0; i < 8; i++) lmem[i] = 16'hA000 + 16'(i * 17);
        run(1, 8'h20, 8, 1'b0, cyc, ev);
        check(cyc == exp_cycles(1, 8), "R6 scatter busy cycles", cyc, exp_cycles(1, 8));
        bad = cmp_scatter(8'h20, 8);
        check(bad == 0, "R2 R4 scatter slices and crc", bad, 0);
        check(order_bad == 0, "R2 scatter ascending order", order_bad, 0);

        // R3 / R5 directed gather
        for (int k = 0; k < N; k++)
            for (int j = 0; j < 3; j++) dmem[k][8'h30 + j] = 16'(k * 256 + j + 5);
        for (int i = 0; i < 12; i++) lmem[i] = 16'hFFFF;
        run(2, 8'h30, 12, 1'b0, cyc, ev);
        check(cyc == exp_cycles(2, 12), "R6 gather busy cycles", cyc, exp_cycles(2, 12));
        bad = cmp_gather(8'h30, 12);
        check(bad == 0, "R3 gather local contents", bad, 0);
        check(!ev, "R5 gather good crc no error", int'(ev), 0);
        check(order_bad == 0, "R3 gather ascending order", order_bad, 0);

        // R5 corrupted crc on target 2, latency unchanged (R6)
        corrupt[2] = 16'h0040;
        run(2, 8'h30, 12, 1'b0, cyc, ev);
        corrupt[2] = '0;
        check(ev, "R5 gather crc mismatch flagged", int'(ev), 1);
        check(cyc == exp_cycles(2, 12), "R6 latency independent of crc result", cyc,
              exp_cycles(2, 12));

        // R8 rejected starts
        reject(1, 6, "R8 scatter length not multiple");
        reject(2, 2, "R8 gather length not multiple");
        reject(0, 0, "R8 zero length");
        reject(3, 4, "R8 illegal op code");

        // R9 start while busy ignored
        for (int k = 0; k < N; k++)
            for (int j = 0; j < 4; j++) dmem[k][8'hE0 + j] = 16'h5A5A;
        run(0, 8'h40, 8, 1'b1, cyc, ev);
        check(cyc == exp_cycles(0, 8), "R9 busy start keeps length", cyc, exp_cycles(0, 8));
        bad = 0;
        for (int k = 0; k < N; k++)
            for (int j = 0; j < 4; j++) if (dmem[k][8'hE0 + j] !== 16'h5A5A) bad++;
        check(bad == 0, "R9 ignored start wrote nothing", bad, 0);
        bad = cmp_bcast(8'h40, 8);
        check(bad == 0, "R9 R1 running transfer intact", bad, 0);
        repeat (3) @(negedge clk);
        check(!busy, "R9 no second transfer launched", int'(busy), 0);

        // random mix with random target readiness
        rnd_ready = 1'b1;
        for (int t = 0; t < 24; t++) begin
            int o, l, b;
            o = $urandom % 3;
            l = (o == 0) ? 1 + ($urandom % 20) : N * (1 + ($urandom % 6));
            b = $urandom % (256 - l);
            for (int i = 0; i < l; i++) lmem[i] = 16'($urandom);
            for (int k = 0; k < N; k++)
                for (int j = 0; j < l; j++) dmem[k][b + j] = 16'($urandom);
            run(o, b, l, 1'b0, cyc, ev);
            case (o)
                0: bad = cmp_bcast(b, l);
                1: bad = cmp_scatter(b, l);
                default: bad = cmp_gather(b, l);
            endcase
            check(bad == 0 && !ev && order_bad == 0, (o == 0) ? "R1 random broadcast" :
                  (o == 1) ? "R2 random scatter" : "R3 random gather", bad, 0);
            check(cyc >= exp_cycles(o, l), "R6 ready gating", cyc, exp_cycles(o, l));
        end
        rnd_ready = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule